// File: doc/BRIEF.md
# Display Panel Rail Power-Up and Power-Down Sequencer

This block orders the switching on and off of five supply rails that feed a display panel: a logic supply, an analog supply, a negative gate-drive rail, a positive gate-drive rail and a common-electrode output. Each rail has one enable line driven by the block. Two comparator flags come back from each rail: one says the rail has passed 90% of its target, the other says it has fallen below its own shutdown threshold. A rail is released by a voltage condition on another rail, not by a fixed delay. Requests that arrive too early are not dropped; they wait until the condition that gates them becomes true.

Two level-sensitive requests drive the sequence. The first request brings up the logic supply alone. The second brings up everything else: analog and negative gate rails first, then the positive gate rail, then the common-electrode output. Dropping the second request runs the sequence backwards, using the fall thresholds, with a timeout that lets each step go ahead even if a rail never discharges. All timeouts count pulses of a 1 ms tick from an outside prescaler, against the parameter `TO_TICKS`.

States, in order: `ST_OFF`, `ST_LOGIC_RAMP`, `ST_LOGIC_ON`, `ST_NEG_RAMP`, `ST_POS_RAMP`, `ST_COM_WAIT`, `ST_COM_RAMP`, `ST_ALL_ON`, `ST_POS_FALL`, `ST_NEG_FALL`. Transitions: OFF→LOGIC_RAMP (supply good and first request), LOGIC_RAMP→LOGIC_ON (logic rail up), LOGIC_ON→OFF (first request low), LOGIC_ON→NEG_RAMP (second request and logic rail up), NEG_RAMP→POS_RAMP (negative rail up), POS_RAMP→COM_WAIT (positive rail up), COM_WAIT→COM_RAMP (control input valid and positive rail up), COM_RAMP→ALL_ON (common and analog rails up), any of NEG_RAMP..ALL_ON→POS_FALL (second request low), POS_FALL→NEG_FALL (positive rail low or timeout), NEG_FALL→LOGIC_ON (negative rail low or timeout), any state→OFF (supply not good).

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset every bit of `rail_en` is 0 and `seq_timeout` is 0.
- R2: The first request takes effect only while `uv_ok` is 1; a request raised earlier waits, and `rail_en[0]` (logic rail) goes to 1 the cycle after `uv_ok` rises. It enables no other rail.
- R3: The second request is acted on only while `rail_up[0]` is 1; an earlier request waits, and then `rail_en[1]` (analog) and `rail_en[2]` (negative gate) go to 1 together.
- R4: `rail_en[3]` (positive gate) goes to 1 only the cycle after `rail_up[2]` was seen at 1.
- R5: `rail_en[4]` (common electrode) goes to 1 only the cycle after both `rail_up[3]` and `ctl_ok` were seen at 1; while `ctl_ok` is 0 the sequence waits with rails 0 to 3 on.
- R6: When the second request drops, `rail_en[3]` and `rail_en[4]` clear first; `rail_en[1]` and `rail_en[2]` clear only after `rail_low[3]` is seen or `TO_TICKS` ticks pass.
- R7: A low first request clears `rail_en[0]` only after rails 1 to 4 are off, which needs `rail_low[2]` or `TO_TICKS` ticks; an earlier low request waits.
- R8: If a rail being brought up does not report 90% within `TO_TICKS` ticks, `seq_timeout` pulses for exactly one cycle and the enables then stay frozen, ignoring both requests, until `uv_ok` falls.
- R9: When `uv_ok` is 0, every bit of `rail_en` is 0 in that same cycle, and the sequence restarts from the off state.
- R10: Dropping the second request during any bring-up step before the timeout starts the power-down sequence from that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| uv_ok | input | 1 | Input supply is above its undervoltage level |
| en1_req | input | 1 | First request: logic rail |
| en2_req | input | 1 | Second request: all other rails |
| ctl_ok | input | 1 | Common-electrode control input is valid |
| rail_up | input | 5 | Per rail: above 90% of target (bit 0 logic .. bit 4 common) |
| rail_low | input | 5 | Per rail: below its shutdown threshold |
| rail_en | output | 5 | Per rail enable, same bit order |
| seq_timeout | output | 1 | One-cycle pulse on a bring-up timeout |

## Verification
Every enable change is due one cycle after the clock edge at which the gating flag or request was seen, because it comes from the state register. The exception is a low `uv_ok`, which clears the enables in the same cycle. A timeout is counted from the second edge in a state, and its pulse appears one cycle after the edge that saw the last tick. The bench keeps to this timing with a behavioural model that advances on the rising edge from the same inputs and a small rail plant. It compares both outputs with the model at every falling edge.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    localparam int RAILS = 5;

    // bit positions of the rails inside the enable and flag vectors
    localparam int RB_LOGIC = 0;
    localparam int RB_ANA   = 1;
    localparam int RB_NEG   = 2;
    localparam int RB_POS   = 3;
    localparam int RB_COM   = 4;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_LOGIC_RAMP,
        ST_LOGIC_ON,
        ST_NEG_RAMP,
        ST_POS_RAMP,
        ST_COM_WAIT,
        ST_COM_RAMP,
        ST_ALL_ON,
        ST_POS_FALL,
        ST_NEG_FALL
    } seq_state_e;

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
    parameter int TO_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = tick && !restart && (cnt_q == LAST);

    // R8: the counter saturates at its last value
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: a restart always empties the count
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
    import rail_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uv_ok,
    input  logic             en1_req,
    input  logic             en2_req,
    input  logic             ctl_ok,
    input  logic [RAILS-1:0] rail_up,
    input  logic [RAILS-1:0] rail_low,
    input  logic             tmo_expire,
    output logic             tmr_restart,
    output logic [RAILS-1:0] rail_en,
    output logic             seq_timeout
);
    seq_state_e       state_q, state_d;
    logic             halted_q;
    logic             halt_set;
    logic             entered_q;
    logic             tmo_q;
    logic [RAILS-1:0] en_dec;

    // next-state selection
    always_comb begin
        state_d  = state_q;
        halt_set = 1'b0;
        if (!uv_ok) begin
            state_d = ST_OFF;
        end else if (!halted_q) begin
            unique case (state_q)
                ST_OFF: begin
                    if (en1_req) state_d = ST_LOGIC_RAMP;
                end
                ST_LOGIC_RAMP: begin
                    if (rail_up[RB_LOGIC])   state_d  = ST_LOGIC_ON;
                    else if (tmo_expire)     halt_set = 1'b1;
                end
                ST_LOGIC_ON: begin
                    if (!en1_req)                          state_d = ST_OFF;
                    else if (en2_req && rail_up[RB_LOGIC]) state_d = ST_NEG_RAMP;
                end
                ST_NEG_RAMP: begin
                    if (!en2_req)            state_d  = ST_POS_FALL;
                    else if (rail_up[RB_NEG]) state_d = ST_POS_RAMP;
                    else if (tmo_expire)     halt_set = 1'b1;
                end
                ST_POS_RAMP: begin
                    if (!en2_req)            state_d  = ST_POS_FALL;
                    else if (rail_up[RB_POS]) state_d = ST_COM_WAIT;
                    else if (tmo_expire)     halt_set = 1'b1;
                end
                ST_COM_WAIT: begin
                    if (!en2_req)                      state_d = ST_POS_FALL;
                    else if (ctl_ok && rail_up[RB_POS]) state_d = ST_COM_RAMP;
                end
                ST_COM_RAMP: begin
                    if (!en2_req)                                state_d  = ST_POS_FALL;
                    else if (rail_up[RB_COM] && rail_up[RB_ANA]) state_d  = ST_ALL_ON;
                    else if (tmo_expire)                         halt_set = 1'b1;
                end
                ST_ALL_ON: begin
                    if (!en2_req) state_d = ST_POS_FALL;
                end
                ST_POS_FALL: begin
                    if (rail_low[RB_POS] || tmo_expire) state_d = ST_NEG_FALL;
                end
                ST_NEG_FALL: begin
                    if (rail_low[RB_NEG] || tmo_expire) state_d = ST_LOGIC_ON;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            halted_q  <= 1'b0;
            entered_q <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            halted_q  <= uv_ok && (halted_q || halt_set);
            entered_q <= (state_d != state_q);
            tmo_q     <= halt_set;
        end
    end

    // enable decode per state
    always_comb begin
        en_dec = '0;
        unique case (state_q)
            ST_OFF:        en_dec = '0;
            ST_LOGIC_RAMP,
            ST_LOGIC_ON,
            ST_NEG_FALL:   en_dec[RB_LOGIC] = 1'b1;
            ST_NEG_RAMP,
            ST_POS_FALL: begin
                en_dec[RB_LOGIC] = 1'b1;
                en_dec[RB_ANA]   = 1'b1;
                en_dec[RB_NEG]   = 1'b1;
            end
            ST_POS_RAMP,
            ST_COM_WAIT: begin
                en_dec[RB_LOGIC] = 1'b1;
                en_dec[RB_ANA]   = 1'b1;
                en_dec[RB_NEG]   = 1'b1;
                en_dec[RB_POS]   = 1'b1;
            end
            ST_COM_RAMP,
            ST_ALL_ON:     en_dec = '1;
            default:       en_dec = '0;
        endcase
    end

    assign rail_en     = uv_ok ? en_dec : '0;
    assign seq_timeout = tmo_q;
    assign tmr_restart = entered_q;

    // R9: a low supply flag returns the machine to off, unfrozen
    p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok |=> (state_q == ST_OFF) && !halted_q);

    // R4: positive gate rail rises only after negative rail was up
    p_pos_after_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[RB_POS]) |-> $past(rail_up[RB_NEG]));

    // R5: common output needs positive rail up and valid control
    p_com_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[RB_COM]) |-> $past(rail_up[RB_POS] && ctl_ok));

    // R3: second-stage rails need the logic rail up and the request
    p_neg_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[RB_NEG]) |-> $past(rail_up[RB_LOGIC] && en2_req));

    // R6: negative rail never goes off while the positive one is on
    p_neg_after_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rail_en[RB_NEG]) && uv_ok) |-> !rail_en[RB_POS]);

    // R7: logic rail drops only with all other rails already off
    p_logic_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rail_en[RB_LOGIC]) && uv_ok) |-> ($past(rail_en[RAILS-1:1]) == '0));

    // R8: timeout is a single-cycle pulse and leaves the enables frozen
    p_tmo_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_timeout |=> !seq_timeout);

    p_tmo_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_timeout && uv_ok) |=> (!uv_ok || $stable(rail_en)));

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int TO_TICKS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             uv_ok,
    input  logic             en1_req,
    input  logic             en2_req,
    input  logic             ctl_ok,
    input  logic [RAILS-1:0] rail_up,
    input  logic [RAILS-1:0] rail_low,
    output logic [RAILS-1:0] rail_en,
    output logic             seq_timeout
);
    logic tmr_restart;
    logic tmo_expire;

    rail_seq_timer #(
        .TO_TICKS (TO_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tick_ms),
        .expire  (tmo_expire)
    );

    rail_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .uv_ok       (uv_ok),
        .en1_req     (en1_req),
        .en2_req     (en2_req),
        .ctl_ok      (ctl_ok),
        .rail_up     (rail_up),
        .rail_low    (rail_low),
        .tmo_expire  (tmo_expire),
        .tmr_restart (tmr_restart),
        .rail_en     (rail_en),
        .seq_timeout (seq_timeout)
    );

endmodule

// File: tb/rail_seq_ctrl_test.sv
module rail_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 5;
    localparam int TICK_DIV   = 4;
    localparam int FULL       = 10;
    localparam int WATCHDOG   = 40000;

    // model phases
    localparam int P_IDLE = 0, P_L_UP = 1, P_L_ON = 2, P_N_UP = 3, P_P_UP = 4;
    localparam int P_C_WT = 5, P_C_UP = 6, P_ALL = 7, P_P_DN = 8, P_N_DN = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       uv_ok = 1'b0, en1_req = 1'b0, en2_req = 1'b0, ctl_ok = 1'b0;
    logic [4:0] rail_up = '0, rail_low = 5'b11111;
    logic [4:0] rail_en;
    logic       seq_timeout;

    int  nchk = 0, nerr = 0, cyc = 0;
    bit  done = 0;
    string tag = "R1";

    // plant state
    int  lvl [5];
    bit  no_rise [5];
    bit  no_fall [5];

    // reference model state
    int  m_ph = P_IDLE, m_ticks = 0;
    bit  m_halt = 0, m_fresh = 0, m_tmo = 0;

    rail_seq_ctrl #(.TO_TICKS(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .uv_ok(uv_ok),
        .en1_req(en1_req), .en2_req(en2_req), .ctl_ok(ctl_ok),
        .rail_up(rail_up), .rail_low(rail_low),
        .rail_en(rail_en), .seq_timeout(seq_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] phase_en(int p);
        case (p)
            P_L_UP, P_L_ON, P_N_DN: return 5'b00001;
            P_N_UP, P_P_DN:         return 5'b00111;
            P_P_UP, P_C_WT:         return 5'b01111;
            P_C_UP, P_ALL:          return 5'b11111;
            default:                return 5'b00000;
        endcase
    endfunction

    // millisecond tick
    always @(posedge clk) begin
        #1 tick_ms = ((cyc % TICK_DIV) == TICK_DIV - 1);
    end

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = P_IDLE; m_halt = 0; m_fresh = 0; m_tmo = 0; m_ticks = 0;
        end else begin
            int  nx;
            bit  hs;
            bit  ex;
            nx = m_ph; hs = 0;
            ex = tick_ms && !m_fresh && (m_ticks == LIM - 1);
            if (!uv_ok) nx = P_IDLE;
            else if (!m_halt) begin
                if (m_ph == P_IDLE && en1_req) nx = P_L_UP;
                else if (m_ph == P_L_UP) begin
                    if (rail_up[0]) nx = P_L_ON; else if (ex) hs = 1;
                end else if (m_ph == P_L_ON) begin
                    if (!en1_req) nx = P_IDLE;
                    else if (en2_req && rail_up[0]) nx = P_N_UP;
                end else if (m_ph >= P_N_UP && m_ph <= P_ALL && !en2_req) nx = P_P_DN;
                else if (m_ph == P_N_UP) begin
                    if (rail_up[2]) nx = P_P_UP; else if (ex) hs = 1;
                end else if (m_ph == P_P_UP) begin
                    if (rail_up[3]) nx = P_C_WT; else if (ex) hs = 1;
                end else if (m_ph == P_C_WT) begin
                    if (ctl_ok && rail_up[3]) nx = P_C_UP;
                end else if (m_ph == P_C_UP) begin
                    if (rail_up[4] && rail_up[1]) nx = P_ALL; else if (ex) hs = 1;
                end else if (m_ph == P_P_DN) begin
                    if (rail_low[3] || ex) nx = P_N_DN;
                end else if (m_ph == P_N_DN) begin
                    if (rail_low[2] || ex) nx = P_L_ON;
                end
            end
            if (m_fresh) m_ticks = 0;
            else if (tick_ms && m_ticks < LIM - 1) m_ticks++;
            m_fresh = (nx != m_ph);
            m_halt  = uv_ok && (m_halt || hs);
            m_tmo   = hs;
            m_ph    = nx;
        end
    end

    // compare, then move the rail plant, at each falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic [4:0] exp_en;
            exp_en = uv_ok ? phase_en(m_ph) : 5'b00000;
            nchk++;
            if (rail_en !== exp_en) begin
                nerr++;
                $display("FAIL %s rail_en actual=%b expected=%b t=%0t", tag, rail_en, exp_en, $time);
            end
            nchk++;
            if (seq_timeout !== m_tmo) begin
                nerr++;
                $display("FAIL %s seq_timeout actual=%b expected=%b t=%0t", tag, seq_timeout, m_tmo, $time);
            end
            for (int i = 0; i < 5; i++) begin
                if (rail_en[i] && !no_rise[i] && lvl[i] < FULL) lvl[i]++;
                else if (!rail_en[i] && !no_fall[i] && lvl[i] > 0) lvl[i]--;
                rail_up[i] = (lvl[i] >= 9);
            end
            rail_low[0] = (lvl[0] == 0);
            rail_low[1] = (lvl[1] == 0);
            rail_low[2] = (lvl[2] <= 3);
            rail_low[3] = (lvl[3] <= 1);
            rail_low[4] = (lvl[4] == 0);
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic full_up();
        uv_ok = 1; en1_req = 1; en2_req = 1; ctl_ok = 1;
        wait_cyc(80);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin lvl[i] = 0; no_rise[i] = 0; no_fall[i] = 0; end
        tag = "R1";
        wait_cyc(5);
        nchk++;
        if (rail_en !== 5'b0 || seq_timeout !== 1'b0) begin
            nerr++;
            $display("FAIL R1 reset outputs actual=%b/%b expected=00000/0", rail_en, seq_timeout);
        end
        rst_n = 1;
        wait_cyc(3);

        // R2: early first request while supply not good
        tag = "R2";
        en1_req = 1;
        wait_cyc(10);
        // R3 R4 R5: second request raised before the logic rail is up; control invalid
        tag = "R3 R4 R5";
        en2_req = 1;
        wait_cyc(4);
        uv_ok = 1;
        wait_cyc(60);
        nchk++;
        if (rail_en !== 5'b01111) begin
            nerr++;
            $display("FAIL R5 waiting for control actual=%b expected=01111", rail_en);
        end
        ctl_ok = 1;
        wait_cyc(40);

        // R6 R7: normal power-down, first request dropped early
        tag = "R6 R7";
        en2_req = 0; en1_req = 0;
        wait_cyc(80);
        nchk++;
        if (rail_en !== 5'b00000) begin
            nerr++;
            $display("FAIL R7 all off actual=%b expected=00000", rail_en);
        end

        // R6: power-down with rails that never discharge (timeout bypass)
        tag = "R6 bypass";
        full_up();
        no_fall[3] = 1; no_fall[2] = 1;
        en2_req = 0;
        wait_cyc(80);
        en1_req = 0;
        wait_cyc(30);
        no_fall[3] = 0; no_fall[2] = 0;
        wait_cyc(20);

        // R10: second request withdrawn during bring-up
        tag = "R10";
        en1_req = 1;
        wait_cyc(14);
        en2_req = 1;
        wait_cyc(6);
        en2_req = 0;
        wait_cyc(60);
        en1_req = 0;
        wait_cyc(30);

        // R8: negative gate rail never rises
        tag = "R8";
        no_rise[2] = 1;
        en1_req = 1; en2_req = 1;
        wait_cyc(80);
        en2_req = 0; en1_req = 0;
        wait_cyc(20);
        nchk++;
        if (rail_en !== 5'b00111) begin
            nerr++;
            $display("FAIL R8 frozen enables actual=%b expected=00111", rail_en);
        end

        // R9: supply drop releases the freeze and clears everything
        tag = "R9";
        uv_ok = 0;
        wait_cyc(15);
        no_rise[2] = 0;
        uv_ok = 1;
        wait_cyc(10);
        full_up();
        uv_ok = 0;
        wait_cyc(20);
        en1_req = 0; en2_req = 0;
        uv_ok = 1;
        wait_cyc(20);

        finish_run();
    end

endmodule